// File: doc/BRIEF.md
# Serial Receive Status and Data Register

This block sits between the byte-level receiver of an asynchronous serial port and a small CPU register bus. Every time the receiver finishes a byte it pulses a one-cycle strobe together with that byte and two quality indications: a framing fault, meaning the stop bit was sampled low, and a parity mismatch. The block stores the byte in a data register. It keeps four sticky status flags: receive-full, overrun, framing fault and parity fault. From these flags and a small enable register it drives a receive interrupt and an error interrupt.

Software cannot clear a flag by writing to it. A flag clears only after two reads in order. First the status register is read while the flag is set, which arms the flag for clearing. Then the data register is read, which clears every armed flag. A byte that completes between those two reads is never dropped silently. If the data register was empty it is loaded and its flags are set anew. Otherwise overrun is raised and the stored byte is kept. A flag set after the status read is not cleared by the data read that follows.

Top module: `serial_rx_status`

## Requirements
- R1: After a synchronous reset, all four flags, the enable register, both interrupts and the read data output are zero.
- R2: A strobe while receive-full is clear, or while it is being cleared in the same cycle, stores the byte in the data register and sets receive-full. A read at address 1 returns that byte on the cycle after the read.
- R3: A strobe while receive-full is set and not being cleared sets the overrun flag and discards the new byte. The data register keeps the unread byte.
- R4: A stored byte that arrives with its framing indication high sets the framing flag.
- R5: A stored byte that arrives with its parity indication high sets the parity flag.
- R6: A flag clears only when the status register is read while that flag is set and the data register is read afterwards. A data read without a prior status read leaves the flags unchanged. A status read alone also leaves them unchanged.
- R7: A flag that becomes set after the status read is not cleared by the data read that follows. That data read still clears the flags the status read saw.
- R8: When a strobe and a clearing data read fall in the same cycle, the data read returns the old byte and the new byte is stored. Every flag the new byte sets stays set until a fresh status read and data read.
- R9: A read at address 0 returns receive-full in bit 0, overrun in bit 1, framing in bit 2 and parity in bit 3, with the upper bits zero. Writes to address 0 have no effect.
- R10: The receive interrupt equals receive-full ANDed with enable bit 0, aligned with the flag.
- R11: The error interrupt is the OR of overrun AND enable bit 1, framing AND enable bit 2, and parity AND enable bit 3, aligned with the flags.
- R12: Address 2 holds the enable register. A write stores the low four bits, and a read returns them with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_strobe | input | 1 | One-cycle pulse: a byte has completed |
| rx_data | input | DATA_W | Completed byte |
| rx_frame_err | input | 1 | Stop bit of this byte was sampled low |
| rx_parity_err | input | 1 | Parity of this byte did not match |
| bus_rd | input | 1 | Register read request |
| bus_wr | input | 1 | Register write request |
| bus_addr | input | ADDR_W | Register address: 0 status, 1 data, 2 enables |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after a read |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The hardest case to reach is a byte that completes between the arming status read and the clearing data read, and above all one that lands in the very cycle of that data read. A free-running random stream rarely lines these events up. Directed sequences therefore place the strobe first after the status read and then on the same edge as the data read, and confirm afterwards which flags survived. A long random run follows. It fires strobes at the same time as bus reads, including reads of every address, and compares every read and both interrupts with a reference model built from the requirements.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  localparam int NFLAG   = 4;
  localparam int F_FULL  = 0;
  localparam int F_OVR   = 1;
  localparam int F_FRM   = 2;
  localparam int F_PAR   = 3;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/rx_flag_core.sv
module rx_flag_core #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_i,
  input  logic          stat_rd,
  input  logic          data_rd,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] armed,
  output logic [NF-1:0] flags_nxt
);
  logic [NF-1:0] armed_nxt;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic clr;
    assign clr = data_rd & armed[i];

    always_comb begin
      flags_nxt[i] = set_i[i] | (flags[i] & ~clr);
      if (set_i[i] || data_rd)
        armed_nxt[i] = 1'b0;
      else
        armed_nxt[i] = armed[i] | (stat_rd & flags[i]);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
        armed[i] <= 1'b0;
      end else begin
        flags[i] <= flags_nxt[i];
        armed[i] <= armed_nxt[i];
      end
    end
  end
endmodule

// File: rtl/rx_ctrl_reg.sv
module rx_ctrl_reg #(
  parameter int NF     = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [NF-1:0]     en_q,
  output logic [NF-1:0]     en_nxt
);
  assign en_nxt = we ? wdata[NF-1:0] : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_nxt;
  end
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] flags_nxt,
  input  logic [NF-1:0] en_nxt,
  output logic          irq_rx,
  output logic          irq_err
);
  logic [NF-1:0] hit;
  assign hit = flags_nxt & en_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      irq_rx  <= hit[0];
      irq_err <= |hit[NF-1:1];
    end
  end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import rx_stat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_strobe,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_rx,
  output logic              irq_err
);
  localparam int PAD_W = DATA_W - NFLAG;

  logic              stat_rd, data_rd, ctrl_wr;
  logic [NFLAG-1:0]  flags, armed, flags_nxt, set_v;
  logic [NFLAG-1:0]  en_q, en_nxt;
  logic [DATA_W-1:0] data_q;
  logic              room, load, ovr;

  assign stat_rd = bus_rd && (bus_addr == ADDR_W'(SEL_STAT));
  assign data_rd = bus_rd && (bus_addr == ADDR_W'(SEL_DATA));
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(SEL_CTRL));

  // the register has room if empty or being emptied by this data read
  assign room = ~flags[F_FULL] | (data_rd & armed[F_FULL]);
  assign load = rx_strobe & room;
  assign ovr  = rx_strobe & ~room;

  always_comb begin
    set_v        = '0;
    set_v[F_FULL] = load;
    set_v[F_OVR]  = ovr;
    set_v[F_FRM]  = load & rx_frame_err;
    set_v[F_PAR]  = load & rx_parity_err;
  end

  rx_flag_core #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_v), .stat_rd(stat_rd), .data_rd(data_rd),
    .flags(flags), .armed(armed), .flags_nxt(flags_nxt)
  );

  rx_ctrl_reg #(.NF(NFLAG), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .we(ctrl_wr), .wdata(bus_wdata),
    .en_q(en_q), .en_nxt(en_nxt)
  );

  rx_irq_gen #(.NF(NFLAG)) u_irq (
    .clk(clk), .rst(rst), .flags_nxt(flags_nxt), .en_nxt(en_nxt),
    .irq_rx(irq_rx), .irq_err(irq_err)
  );

  always_ff @(posedge clk) begin
    if (rst)       data_q <= '0;
    else if (load) data_q <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(SEL_STAT): bus_rdata <= {{PAD_W{1'b0}}, flags};
        ADDR_W'(SEL_DATA): bus_rdata <= data_q;
        ADDR_W'(SEL_CTRL): bus_rdata <= {{PAD_W{1'b0}}, en_q};
        default:           bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_status_chk.sv
module serial_rx_status_chk #(
  parameter int NF     = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_strobe,
  input logic [DATA_W-1:0] rx_data,
  input logic              data_rd,
  input logic [NF-1:0]     flags,
  input logic [NF-1:0]     armed,
  input logic [NF-1:0]     en,
  input logic [DATA_W-1:0] data_q,
  input logic              irq_rx,
  input logic              irq_err
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (flags == '0 && armed == '0 && en == '0 && !irq_rx && !irq_err));

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (rx_strobe && !flags[0]) |=> (flags[0] && data_q == $past(rx_data)));

  a_r3_keep_unread: assert property (@(posedge clk) disable iff (rst)
    (rx_strobe && flags[0] && !(data_rd && armed[0])) |=> (flags[1] && $stable(data_q)));

  // R6: an unarmed flag never drops
  a_r6_unarmed_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & $past(flags & ~armed)) == $past(flags & ~armed)));

  // R6: arming only ever covers flags that are set
  a_r6_arm_subset: assert property (@(posedge clk) disable iff (rst)
    (armed & ~flags) == '0);

  a_r10_irq_rx: assert property (@(posedge clk) disable iff (rst)
    irq_rx == (flags[0] && en[0]));

  a_r11_irq_err: assert property (@(posedge clk) disable iff (rst)
    irq_err == (|(flags[NF-1:1] & en[NF-1:1])));
endmodule

bind serial_rx_status serial_rx_status_chk #(.NF(rx_stat_pkg::NFLAG), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rx_strobe(rx_strobe), .rx_data(rx_data), .data_rd(data_rd),
  .flags(flags), .armed(armed), .en(en_q), .data_q(data_q),
  .irq_rx(irq_rx), .irq_err(irq_err)
);

// File: tb/serial_rx_status_tb.sv
module serial_rx_status_tb;
  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_strobe = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          rx_frame_err = 1'b0;
  logic          rx_parity_err = 1'b0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_rx, irq_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [3:0]    m_flags = '0, m_arm = '0, m_en = '0;
  logic [DW-1:0] m_data = '0;
  logic [DW-1:0] m_rd = '0;

  always #2 clk = ~clk;

  serial_rx_status #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .rx_strobe(rx_strobe), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] read_value(input logic [AW-1:0] a);
    case (a)
      2'd0:    return {4'b0, m_flags};
      2'd1:    return m_data;
      2'd2:    return {4'b0, m_en};
      default: return '0;
    endcase
  endfunction

  // one bus/receiver cycle; tag names the requirement under test
  task automatic step(input string tag, input bit stb, input logic [DW-1:0] d,
                      input bit fe, input bit pe, input bit rd, input bit wr,
                      input logic [AW-1:0] a, input logic [DW-1:0] wd);
    logic [3:0] clr, setv, nf;
    bit room, srd, drd;
    @(negedge clk);
    rx_strobe = stb; rx_data = d; rx_frame_err = fe; rx_parity_err = pe;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    srd  = rd && a == 2'd0;
    drd  = rd && a == 2'd1;
    if (rd) m_rd = read_value(a);
    clr  = drd ? m_arm : 4'b0;
    room = !m_flags[0] || clr[0];
    setv = {stb && room && pe, stb && room && fe, stb && !room, stb && room};
    nf   = (m_flags & ~clr) | setv;
    m_arm = drd ? 4'b0 : (m_arm | (srd ? m_flags : 4'b0));
    m_arm = m_arm & ~setv;
    if (stb && room) m_data = d;
    if (wr && a == 2'd2) m_en = wd[3:0];
    m_flags = nf;
    #1;
    if (rd) check({tag, " rdata"}, bus_rdata, m_rd);
    check("R10 irq_rx", {7'b0, irq_rx}, {7'b0, m_flags[0] & m_en[0]});
    check("R11 irq_err", {7'b0, irq_err}, {7'b0, |(m_flags[3:1] & m_en[3:1])});
    rx_strobe = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    step(tag, 0, '0, 0, 0, 1, 0, a, '0);
    check({tag, " fixed"}, bus_rdata, exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 rdata", bus_rdata, '0);
    check("R1 irqs", {6'b0, irq_rx, irq_err}, '0);
    rd_expect("R1 status", 2'd0, 8'h00);
    rd_expect("R1 ctrl", 2'd2, 8'h00);

    // R12 enables, R10/R11 interrupts
    step("R12 wr", 0, '0, 0, 0, 0, 1, 2'd2, 8'hFF);
    rd_expect("R12 ctrl", 2'd2, 8'h0F);

    // R2 load, R6 clean clear
    step("R2 byte", 1, 8'hA8, 0, 0, 0, 0, 2'd0, '0);
    check("R10 irq set", {7'b0, irq_rx}, 8'h01);
    rd_expect("R2 R9 status", 2'd0, 8'h01);
    rd_expect("R2 data", 2'd1, 8'hA8);
    rd_expect("R6 cleared", 2'd0, 8'h00);

    // R4 framing, R6 data read alone keeps flags
    step("R4 byte", 1, 8'h3C, 1, 0, 0, 0, 2'd0, '0);
    check("R11 irq framing", {7'b0, irq_err}, 8'h01);
    rd_expect("R6 data only", 2'd1, 8'h3C);
    rd_expect("R4 R6 status", 2'd0, 8'h05);

    // R3 overrun keeps unread byte (status already armed full+framing)
    step("R3 byte", 1, 8'h77, 0, 0, 0, 0, 2'd0, '0);
    // R7: overrun arrived after status read -> survives the data read
    rd_expect("R3 data kept", 2'd1, 8'h3C);
    rd_expect("R7 ovr stays", 2'd0, 8'h02);
    rd_expect("R7 data", 2'd1, 8'h3C);
    rd_expect("R7 all clear", 2'd0, 8'h00);

    // R9 write to status ignored
    step("R2 byte2", 1, 8'h5A, 0, 0, 0, 0, 2'd0, '0);
    step("R9 wr stat", 0, '0, 0, 0, 0, 1, 2'd0, 8'h00);
    rd_expect("R9 ignored", 2'd0, 8'h01);

    // R8 strobe together with the clearing data read; R5 parity
    step("R8 collide", 1, 8'hC3, 0, 1, 1, 0, 2'd1, '0);
    check("R8 old byte", bus_rdata, 8'h5A);
    rd_expect("R5 R8 status", 2'd0, 8'h09);
    rd_expect("R8 new byte", 2'd1, 8'hC3);
    rd_expect("R8 cleared", 2'd0, 8'h00);

    // R11 enable masking
    step("R12 wr2", 0, '0, 0, 0, 0, 1, 2'd2, 8'h01);
    step("R5 byte", 1, 8'h11, 0, 1, 0, 0, 2'd0, '0);
    check("R11 masked", {7'b0, irq_err}, 8'h00);
    rd_expect("R5 status", 2'd0, 8'h09);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 19);
      bit stb = ($urandom_range(0, 9) < 3);
      logic [DW-1:0] d = DW'($urandom);
      bit fe = ($urandom_range(0, 3) == 0);
      bit pe = ($urandom_range(0, 3) == 0);
      if (op < 6)       step("R9 rnd", stb, d, fe, pe, 1, 0, 2'd0, '0);
      else if (op < 12) step("R2 rnd", stb, d, fe, pe, 1, 0, 2'd1, '0);
      else if (op < 13) step("R12 rnd", stb, d, fe, pe, 1, 0, 2'd2, '0);
      else if (op < 14) step("R12 rnd", stb, d, fe, pe, 1, 0, 2'd3, '0);
      else if (op < 15) step("R12 rnd", stb, d, fe, pe, 0, 1, 2'd2, DW'($urandom));
      else if (op < 16) step("R9 rnd", stb, d, fe, pe, 0, 1, 2'd0, DW'($urandom));
      else              step("R3 rnd", stb, d, fe, pe, 0, 0, 2'd0, '0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule